// File: doc/BRIEF.md
# EEPROM Write-Completion Acknowledge Poller

After a serial EEPROM accepts a page of data it runs an internal programming cycle. During that cycle it does not answer on the bus. This sequencer sits on top of an I2C transaction master and finds out when that cycle is over. It sends repeated probe frames that contain only an address: START, the 7-bit device address with the direction bit cleared, then STOP. The frames carry no memory address and no data. A device that acknowledges its address has finished writing. A device that does not acknowledge is still busy.

Software or a controlling state machine gives one start pulse, together with the device address, a wait interval in clock cycles and an attempt limit. Before each probe the poller waits for the master to report the bus idle. After every NACK it waits out the interval. It stops at the first ACK or when the attempt limit is used up. At the end it gives a one-cycle `done` pulse and holds a `ready` or `timed_out` flag until the next accepted start.

Top module: `ack_poller`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `done`, `ready`, `timed_out` and `probe_go` are all 0.
- R2: A probe request is a single-cycle `probe_go` pulse. It is raised only in a cycle where `mst_idle` is 1. While it is high, `probe_byte` equals the latched device address in bits 7:1 with bit 0 (direction) at 0.
- R3: A start accepted in cycle s gives the first probe in cycle s+1 if `mst_idle` is 1 then. Otherwise the first probe comes in the first later cycle in which `mst_idle` is 1.
- R4: A response reported with `mst_nack`=0 ends polling. `done` pulses in the next cycle with `ready`=1 and `timed_out`=0, and no further probe follows.
- R5: A response reported with `mst_nack`=1 in cycle d, while attempts remain, gives the next probe no earlier than cycle d+G+1. G is the interval, with an interval of 0 treated as 1. The probe comes in that cycle when the bus is idle.
- R6: When the number of probes sent reaches the attempt limit and the last one is answered with NACK, `done` pulses in the next cycle with `timed_out`=1 and `ready`=0. Exactly limit probes are sent.
- R7: An attempt limit of 0 sends no probe. It raises `done` and `timed_out` in the cycle after the start is accepted.
- R8: A `start` pulse while polling is running is ignored. It changes neither the probed address nor the number of probes.
- R9: `ready` and `timed_out` keep their value after `done`. Both are cleared in the cycle after the next start is accepted.
- R10: `done` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin polling (accepted only when idle) |
| dev_addr | input | AW | 7-bit device address |
| interval | input | IW | Wait between attempts, in clock cycles |
| max_tries | input | TW | Attempt limit |
| mst_idle | input | 1 | Master reports the bus idle (previous STOP complete) |
| mst_done | input | 1 | Master reports the end of an address-only frame |
| mst_nack | input | 1 | Valid with `mst_done`: 1 if the address was not acknowledged |
| probe_go | output | 1 | Request one address-only frame from the master |
| probe_byte | output | AW+1 | Address byte for the frame, direction bit 0 |
| done | output | 1 | One-cycle pulse when polling ends |
| ready | output | 1 | Polling ended on an ACK |
| timed_out | output | 1 | Polling ended with the attempt limit used up |

## Verification
A wrong attempt count shows up as a probe total that differs from the smaller of the ACK position and the limit. It can also show up as a `timed_out` that disagrees with `ready`. Both are visible at the `done` pulse of that same run. A wrong gap timer moves the next `probe_go` off cycle d+G+1 by the size of the error, so the bench sees it at the very next probe. A wrongly latched address or a start that is not ignored changes `probe_byte` on the following probe.

// File: rtl/ackpoll_pkg.sv
package ackpoll_pkg;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_WAIT_BUS  = 2'd1,
    ST_WAIT_RESP = 2'd2,
    ST_GAP       = 2'd3
  } poll_state_t;

  // Effective gap length: an interval of zero still leaves one cycle.
  function automatic int unsigned gap_len(input int unsigned ival);
    return (ival == 0) ? 1 : ival;
  endfunction

  // Address byte for a write-direction probe.
  function automatic logic [7:0] probe_addr_byte(input logic [6:0] a);
    return {a, 1'b0};
  endfunction

endpackage

// File: rtl/ackpoll_gap_timer.sv
module ackpoll_gap_timer #(
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [IW-1:0] load_val,
  input  logic          run,
  output logic          expired
);
  import ackpoll_pkg::*;

  logic [IW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= IW'(gap_len(int'(load_val)));
    end else if (run && cnt_q > 1) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q <= 1);

endmodule

// File: rtl/ackpoll_try_counter.sv
module ackpoll_try_counter #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          inc,
  input  logic [TW-1:0] limit,
  output logic [TW-1:0] tries,
  output logic          at_limit
);
  logic [TW-1:0] tries_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tries_q <= '0;
    end else if (clear) begin
      tries_q <= '0;
    end else if (inc) begin
      tries_q <= tries_q + 1'b1;
    end
  end

  assign tries    = tries_q;
  assign at_limit = (tries_q >= limit);

endmodule

// File: rtl/ack_poller.sv
module ack_poller #(
  parameter int AW = 7,
  parameter int IW = 16,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] dev_addr,
  input  logic [IW-1:0] interval,
  input  logic [TW-1:0] max_tries,
  input  logic          mst_idle,
  input  logic          mst_done,
  input  logic          mst_nack,
  output logic          probe_go,
  output logic [AW:0]   probe_byte,
  output logic          done,
  output logic          ready,
  output logic          timed_out
);
  import ackpoll_pkg::*;

  poll_state_t   st_q, st_d;
  logic [AW-1:0] addr_q;
  logic [IW-1:0] ival_q;
  logic [TW-1:0] lim_q;
  logic          done_q, ready_q, tout_q;

  // Named internal events
  logic          busy;
  logic          accept;
  logic          zero_lim;
  logic          resp_seen;
  logic          ack_ok;
  logic          nack_last;
  logic          nack_retry;
  logic          gap_expired;
  logic          at_limit;
  logic [TW-1:0] tries;

  assign busy       = (st_q != ST_IDLE);
  assign accept     = (st_q == ST_IDLE) && start;
  assign zero_lim   = accept && (max_tries == '0);
  assign probe_go   = (st_q == ST_WAIT_BUS) && mst_idle;
  assign resp_seen  = (st_q == ST_WAIT_RESP) && mst_done;
  assign ack_ok     = resp_seen && !mst_nack;
  assign nack_last  = resp_seen && mst_nack && at_limit;
  assign nack_retry = resp_seen && mst_nack && !at_limit;

  ackpoll_try_counter #(.TW(TW)) tries_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .inc      (probe_go),
    .limit    (lim_q),
    .tries    (tries),
    .at_limit (at_limit)
  );

  ackpoll_gap_timer #(.IW(IW)) gap_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (nack_retry),
    .load_val (ival_q),
    .run      (st_q == ST_GAP),
    .expired  (gap_expired)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:      if (accept && !zero_lim) st_d = ST_WAIT_BUS;
      ST_WAIT_BUS:  if (probe_go) st_d = ST_WAIT_RESP;
      ST_WAIT_RESP: begin
        if (ack_ok || nack_last) st_d = ST_IDLE;
        else if (nack_retry)     st_d = ST_GAP;
      end
      ST_GAP:       if (gap_expired) st_d = ST_WAIT_BUS;
      default:      st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      ival_q  <= '0;
      lim_q   <= '0;
      done_q  <= 1'b0;
      ready_q <= 1'b0;
      tout_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= ack_ok || nack_last || zero_lim;
      if (accept) begin
        addr_q  <= dev_addr;
        ival_q  <= interval;
        lim_q   <= max_tries;
        ready_q <= 1'b0;
        tout_q  <= zero_lim;
      end
      if (ack_ok)    ready_q <= 1'b1;
      if (nack_last) tout_q  <= 1'b1;
    end
  end

  assign probe_byte = {addr_q, 1'b0};
  assign done       = done_q;
  assign ready      = ready_q;
  assign timed_out  = tout_q;

endmodule

// File: rtl/ack_poller_sva.sv
module ack_poller_sva #(
  parameter int AW = 7,
  parameter int TW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          mst_idle,
  input logic          probe_go,
  input logic [AW:0]   probe_byte,
  input logic          done,
  input logic          ready,
  input logic          timed_out,
  input logic          busy,
  input logic [TW-1:0] tries,
  input logic [TW-1:0] lim_q
);

  assert_probe_needs_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    probe_go |-> mst_idle);

  assert_probe_write_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
    probe_go |-> (probe_byte[0] == 1'b0));

  assert_probe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    probe_go |=> !probe_go);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_result_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $onehot({ready, timed_out}));

  assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready && timed_out));

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(probe_byte));

  assert_tries_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (tries <= lim_q));

endmodule

bind ack_poller ack_poller_sva #(.AW(AW), .TW(TW)) sva_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .mst_idle   (mst_idle),
  .probe_go   (probe_go),
  .probe_byte (probe_byte),
  .done       (done),
  .ready      (ready),
  .timed_out  (timed_out),
  .busy       (busy),
  .tries      (tries),
  .lim_q      (lim_q)
);

// File: tb/ack_poller_tb_top.sv
module ack_poller_tb_top;
  localparam int AW = 7;
  localparam int IW = 16;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] dev_addr = '0;
  logic [IW-1:0] interval = '0;
  logic [TW-1:0] max_tries = '0;
  logic          mst_idle = 1'b1;
  logic          mst_done = 1'b0;
  logic          mst_nack = 1'b0;
  logic          probe_go;
  logic [AW:0]   probe_byte;
  logic          done, ready, timed_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ack_poller #(.AW(AW), .IW(IW), .TW(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .dev_addr(dev_addr),
    .interval(interval), .max_tries(max_tries), .mst_idle(mst_idle),
    .mst_done(mst_done), .mst_nack(mst_nack), .probe_go(probe_go),
    .probe_byte(probe_byte), .done(done), .ready(ready), .timed_out(timed_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int gap_of(input int iv);
    return (iv < 1) ? 1 : iv;
  endfunction

  // One polling run: device ACKs on probe number ackat (never if ackat > lim).
  task automatic run_case(input int intv, input int lim, input int ackat,
                          input int hold, input logic [AW-1:0] a);
    int  n = 0;
    int  p = -1000;
    int  d = -1000;
    int  lastnack = -1000;
    int  scyc;
    int  expn;
    bit  nk = 1'b1;
    bit  fin = 1'b0;
    bit  exp_ready;
    expn = (lim == 0) ? 0 : ((ackat <= lim) ? ackat : lim);
    exp_ready = (lim > 0) && (ackat <= lim);
    @(negedge clk);
    start = 1'b1; dev_addr = a; interval = IW'(intv); max_tries = TW'(lim);
    mst_done = 1'b0; mst_idle = (hold == 0);
    scyc = cyc;
    for (int k = 0; k < 400 && !fin; k++) begin
      @(negedge clk);
      start    = (n == 1) && (cyc == p + 1);
      dev_addr = start ? ~a : a;
      mst_done = (cyc == d);
      mst_nack = nk;
      mst_idle = (cyc > scyc + hold) && !(cyc > p && cyc <= p + 3);
      #1;
      if (probe_go) begin
        n++;
        check(probe_byte == {a, 1'b0}, "R2 probe byte", int'(probe_byte), int'({a, 1'b0}));
        check(mst_idle, "R2 probe while bus busy", 0, 1);
        if (n == 1)
          check(cyc == scyc + 1 + hold, "R3 first probe cycle", cyc, scyc + 1 + hold);
        else
          check(cyc == lastnack + gap_of(intv) + 1, "R5 retry gap", cyc - lastnack,
                gap_of(intv) + 1);
        check(n <= expn, "R8 probe count bound", n, expn);
        p  = cyc;
        d  = cyc + 2;
        nk = (n != ackat);
      end
      if (cyc == d && nk) lastnack = cyc;
      if (lim > 0 && n == 1 && cyc == p)
        check(!ready && !timed_out, "R9 flags cleared on start", int'({ready, timed_out}), 0);
      if (done) begin
        fin = 1'b1;
        check(n == expn, exp_ready ? "R4 probes until ACK" : "R6 probes at limit", n, expn);
        check(ready == exp_ready, exp_ready ? "R4 ready" : "R6 ready", ready, exp_ready);
        check(timed_out == !exp_ready, exp_ready ? "R4 timed_out" : "R6 timed_out",
              timed_out, !exp_ready);
        if (lim == 0) check(cyc == scyc + 1, "R7 zero limit done cycle", cyc, scyc + 1);
        else          check(cyc == d + 1, "R4 done follows response", cyc, d + 1);
      end
    end
    if (!fin) check(1'b0, "R4 done never seen", 0, 1);
    mst_done = 1'b0; start = 1'b0; mst_idle = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      #1;
      check(!done, "R10 done single cycle", done, 0);
      check(!probe_go, "R4 no probe after end", probe_go, 0);
      check(ready == exp_ready && timed_out == !exp_ready, "R9 flags held",
            int'({ready, timed_out}), int'({exp_ready, !exp_ready}));
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    #1;
    check(!done && !ready && !timed_out && !probe_go, "R1 outputs in reset",
          int'({done, ready, timed_out, probe_go}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(!done && !ready && !timed_out && !probe_go, "R1 outputs after reset",
          int'({done, ready, timed_out, probe_go}), 0);
    for (int iv = 0; iv < 4; iv++)
      for (int lm = 0; lm < 5; lm++)
        for (int ak = 1; ak < 6; ak++)
          run_case(iv, lm, ak, (iv + lm + ak) % 3, AW'(7'h50 + iv * 5 + lm * 3 + ak));
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule